// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits on the host side of a register bus. Each host access is a single 32-bit dword. The block turns those dword writes into whole writes for targets that are wider than the bus. It serves 128-bit control registers, which hold four dwords, and 64-bit SRAM words, which hold two dwords. One shared collector holds the dwords of the wide target currently being assembled. It holds them together with a dword-valid mask and the aligned address of that target. The target is written in one step, through the commit port, once every dword of it is present. Plain 32-bit registers go straight through to the commit port without touching the collector.

The register space is divided into pages of 2^PAGE_BITS bytes. By default a page is 0x2000 bytes, and the effective address is page × 0x2000 plus the in-page offset. Two write-only descriptor-pointer registers exist in every page, and they follow their own rules. A write to the top dword of one of them always commits that register, and any low dword that is not held fills with zero. A write to one of their lower dwords is dropped when the collector is busy with a different target. One quirk is kept on purpose: a timer-command write in page 0 empties the collector.

Both sides use valid/ready handshakes. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. The commit port holds `cm_valid` and its payload steady until an edge where `cm_ready` is high. `wr_ready` is high only when the commit register is empty or is being drained in the same cycle. Because of this, no write is accepted while a commit is stalled, not even a write that would produce no output.

Top module: `wide_write_collector`

## Requirements
- R1: After synchronous reset `cm_valid` is 0, `wr_ready` is 1 and the collector is empty. A later write of one dword of a wide register therefore produces no commit.
- R2: Address bit ADDR_W-1 = 0 selects register space. An offset that is neither special nor direct there is a 128-bit register with base `addr & ~0xF`, and `addr[3:2]` selects the dword. The register commits only once all four dwords have been written, in any order. The commit has `cm_kind` = 2, `cm_addr` = base and dword 0 in `cm_data[31:0]`.
- R3: Address bit ADDR_W-1 = 1 selects SRAM. An SRAM word has base `addr & ~0x7`, and `addr[2]` selects the dword. The word commits once both of its dwords are held, with `cm_kind` = 1 and `cm_data[127:64]` = 0.
- R4: A write to a wide target other than the one held restarts collection with only that dword valid. Dwords already collected for the previous target are lost.
- R5: Descriptor registers sit at in-page offsets 0x830 and 0xa10. A write to their top dword (offset +0xC) always commits at once, with `cm_kind` = 3. A low dword fills with zero unless the collector holds that same register with that dword valid.
- R6: A write to a lower dword of a descriptor register is discarded while the collector holds dwords of a different target. Both the held contents and the held address remain as they were.
- R7: Lower dwords of a descriptor register are collected when the collector is empty or already holds that register. They then appear in the commit made by its top dword.
- R8: Writes to the direct offsets 0x400 and 0x420 in any page commit at once, with `cm_kind` = 0, `cm_addr` = the write address and `cm_data[31:0]` = the data. They leave the collector untouched, except as stated in R9.
- R9: A write to offset 0x420 in page 0 empties the collector, so a partly collected value is lost. The same offset in any other page does not empty it.
- R10: Register behaviour repeats in every page. The commit address carries the page, as page × 0x2000 + offset.
- R11: While `cm_valid` = 1 and `cm_ready` = 0, the commit payload stays stable and `wr_ready` = 0.
- R12: Writing the same dword again before the commit replaces the held value, so the last write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host dword write valid |
| wr_ready | output | 1 | Block can accept a write this cycle |
| wr_addr | input | ADDR_W | Byte address of the dword |
| wr_data | input | 32 | Dword data |
| cm_valid | output | 1 | Commit pending |
| cm_ready | input | 1 | Downstream accepts the commit |
| cm_kind | output | 2 | 0 dword, 1 SRAM 64-bit, 2 register 128-bit, 3 descriptor |
| cm_addr | output | ADDR_W | Base address of the committed target |
| cm_data | output | 128 | Committed data, dword 0 in bits 31:0 |

## Verification
The bench builds the block with its defaults: ADDR_W = 20 and PAGE_BITS = 13. This gives 64 pages of 0x2000 bytes below the SRAM half of the map. With that layout, descriptor and direct registers can be reached in pages 0, 1 and 3. So can the page-0-only timer quirk, next to its harmless copy in page 1, and SRAM words that sit above every page. Holding `cm_ready` low makes the stall path observable.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    K_DWORD = 2'd0,
    K_SRAM  = 2'd1,
    K_CSR   = 2'd2,
    K_DESC  = 2'd3
  } wkind_e;

  typedef logic [LANES-1:0][DW-1:0] lanes_t;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned OFF_EVQ   = 'h400,
  parameter int unsigned OFF_TMR   = 'h420,
  parameter int unsigned OFF_RXD   = 'h830,
  parameter int unsigned OFF_TXD   = 'ha10
) (
  input  logic [ADDR_W-1:0] addr,
  output wkind_e            kind,
  output logic [1:0]        lane,
  output logic              last_lane,
  output logic              tmr_page0,
  output logic [ADDR_W-1:0] base
);
  localparam int unsigned HI_W = ADDR_W - 1 - PAGE_BITS;

  logic                 in_sram;
  logic [PAGE_BITS-1:0] off;
  logic [HI_W-1:0]      page;
  logic [1:0]           desc_hit;
  logic [1:0]           dir_hit;

  assign in_sram = addr[ADDR_W-1];
  assign off     = addr[PAGE_BITS-1:0];
  assign page    = addr[ADDR_W-2:PAGE_BITS];

  for (genvar g = 0; g < 2; g++) begin : g_desc
    localparam logic [PAGE_BITS-1:0] DOFF = PAGE_BITS'((g == 0) ? OFF_RXD : OFF_TXD);
    assign desc_hit[g] = !in_sram && (off[PAGE_BITS-1:4] == DOFF[PAGE_BITS-1:4]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_dir
    localparam logic [PAGE_BITS-1:0] XOFF = PAGE_BITS'((g == 0) ? OFF_EVQ : OFF_TMR);
    assign dir_hit[g] = !in_sram && (off[PAGE_BITS-1:2] == XOFF[PAGE_BITS-1:2]);
  end

  assign tmr_page0 = dir_hit[1] && (page == '0);

  always_comb begin
    if (in_sram) begin
      kind = K_SRAM;
    end else if (|dir_hit) begin
      kind = K_DWORD;
    end else if (|desc_hit) begin
      kind = K_DESC;
    end else begin
      kind = K_CSR;
    end
  end

  always_comb begin
    lane      = addr[3:2];
    base      = {addr[ADDR_W-1:4], 4'b0000};
    last_lane = (addr[3:2] == 2'd3);
    unique case (kind)
      K_SRAM: begin
        lane      = {1'b0, addr[2]};
        base      = {addr[ADDR_W-1:3], 3'b000};
        last_lane = addr[2];
      end
      K_DWORD: begin
        base = addr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  wkind_e            kind,
  input  logic [1:0]        lane,
  input  logic              last_lane,
  input  logic              tmr_page0,
  input  logic [ADDR_W-1:0] base,
  input  logic [DW-1:0]     wdata,
  output logic              emit,
  output wkind_e            emit_kind,
  output logic [ADDR_W-1:0] emit_addr,
  output lanes_t            emit_data,
  output logic [LANES-1:0]  mask_q
);
  logic [ADDR_W-1:0] tag_q, tag_n;
  lanes_t            data_q, data_n, merged;
  logic [LANES-1:0]  mask_n, merged_mask, full_mask;
  logic              hit, busy;

  assign busy = |mask_q;
  assign hit  = busy && (tag_q == base);

  always_comb begin
    merged       = data_q;
    merged[lane] = wdata;
    merged_mask  = (hit ? mask_q : '0) | (LANES'(1) << lane);
    full_mask    = (kind == K_SRAM) ? 4'b0011 : 4'b1111;
  end

  always_comb begin
    mask_n    = mask_q;
    tag_n     = tag_q;
    data_n    = data_q;
    emit      = 1'b0;
    emit_kind = kind;
    emit_addr = base;
    emit_data = '0;
    if (take) begin
      unique case (kind)
        K_DWORD: begin
          emit         = 1'b1;
          emit_data[0] = wdata;
          if (tmr_page0) mask_n = '0;
        end
        K_CSR, K_SRAM: begin
          data_n = merged;
          if (merged_mask == full_mask) begin
            emit   = 1'b1;
            mask_n = '0;
            for (int i = 0; i < LANES; i++) begin
              emit_data[i] = full_mask[i] ? merged[i] : '0;
            end
          end else begin
            mask_n = merged_mask;
            tag_n  = base;
          end
        end
        K_DESC: begin
          if (last_lane) begin
            emit   = 1'b1;
            mask_n = '0;
            for (int i = 0; i < LANES; i++) begin
              if (i == int'(lane))            emit_data[i] = wdata;
              else if (hit && mask_q[i])      emit_data[i] = data_q[i];
              else                            emit_data[i] = '0;
            end
          end else if (!busy || hit) begin
            data_n = merged;
            mask_n = merged_mask;
            tag_n  = base;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      mask_q <= mask_n;
      tag_q  <= tag_n;
      data_q <= data_n;
    end
  end
endmodule

// File: rtl/wrc_out_stage.sv
module wrc_out_stage #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] in_pl,
  output logic          free,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [PW-1:0] o_pl
);
  assign free = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_pl    <= '0;
    end else if (free) begin
      o_valid <= load;
      if (load) o_pl <= in_pl;
    end
  end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned OFF_EVQ   = 'h400,
  parameter int unsigned OFF_TMR   = 'h420,
  parameter int unsigned OFF_RXD   = 'h830,
  parameter int unsigned OFF_TXD   = 'ha10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              cm_valid,
  input  logic              cm_ready,
  output logic [1:0]        cm_kind,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [127:0]      cm_data
);
  localparam int unsigned PW = 2 + ADDR_W + LANES * DW;

  wkind_e            d_kind, e_kind;
  logic [1:0]        d_lane;
  logic              d_last, d_tmr0, take, emit;
  logic [ADDR_W-1:0] d_base, e_addr;
  lanes_t            e_data;
  logic [LANES-1:0]  col_mask;
  logic [PW-1:0]     out_pl;

  wrc_decode #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .OFF_EVQ(OFF_EVQ),
    .OFF_TMR(OFF_TMR), .OFF_RXD(OFF_RXD), .OFF_TXD(OFF_TXD)
  ) u_dec (
    .addr(wr_addr), .kind(d_kind), .lane(d_lane), .last_lane(d_last),
    .tmr_page0(d_tmr0), .base(d_base)
  );

  assign take = wr_valid && wr_ready;

  wrc_collector #(.ADDR_W(ADDR_W)) u_col (
    .clk(clk), .rst(rst), .take(take), .kind(d_kind), .lane(d_lane),
    .last_lane(d_last), .tmr_page0(d_tmr0), .base(d_base), .wdata(wr_data),
    .emit(emit), .emit_kind(e_kind), .emit_addr(e_addr), .emit_data(e_data),
    .mask_q(col_mask)
  );

  wrc_out_stage #(.PW(PW)) u_out (
    .clk(clk), .rst(rst), .load(emit), .in_pl({e_kind, e_addr, e_data}),
    .free(wr_ready), .o_valid(cm_valid), .o_ready(cm_ready), .o_pl(out_pl)
  );

  assign cm_kind = out_pl[PW-1 -: 2];
  assign cm_addr = out_pl[LANES*DW +: ADDR_W];
  assign cm_data = out_pl[LANES*DW-1:0];
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned OFF_EVQ   = 'h400,
  parameter int unsigned OFF_TMR   = 'h420,
  parameter int unsigned OFF_RXD   = 'h830,
  parameter int unsigned OFF_TXD   = 'ha10
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              cm_valid,
  input logic              cm_ready,
  input logic [1:0]        cm_kind,
  input logic [ADDR_W-1:0] cm_addr,
  input logic [127:0]      cm_data,
  input logic [3:0]        col_mask
);
  localparam logic [PAGE_BITS-1:0] C_EVQ = PAGE_BITS'(OFF_EVQ);
  localparam logic [PAGE_BITS-1:0] C_TMR = PAGE_BITS'(OFF_TMR);
  localparam logic [PAGE_BITS-1:0] C_RXH = PAGE_BITS'(OFF_RXD + 'hC);
  localparam logic [PAGE_BITS-1:0] C_TXH = PAGE_BITS'(OFF_TXD + 'hC);

  logic                 acc, regsp;
  logic [PAGE_BITS-1:0] off;
  assign acc   = wr_valid && wr_ready;
  assign regsp = !wr_addr[ADDR_W-1];
  assign off   = {wr_addr[PAGE_BITS-1:2], 2'b00};

  // R1: reset leaves no pending commit and an empty collector
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !cm_valid && col_mask == 4'd0);

  assert_csr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    cm_valid && cm_kind == 2'd2 |-> cm_addr[3:0] == 4'd0);

  assert_sram_shape_R3: assert property (@(posedge clk) disable iff (rst)
    cm_valid && cm_kind == 2'd1 |-> cm_data[127:64] == 64'd0 && cm_addr[2:0] == 3'd0);

  assert_desc_top_R5: assert property (@(posedge clk) disable iff (rst)
    acc && regsp && (off == C_RXH || off == C_TXH)
    |=> cm_valid && cm_kind == 2'd3 && cm_data[127:96] == $past(wr_data) && cm_addr[3:0] == 4'd0);

  assert_direct_pass_R8: assert property (@(posedge clk) disable iff (rst)
    acc && regsp && (off == C_EVQ || off == C_TMR)
    |=> cm_valid && cm_kind == 2'd0 && cm_data[31:0] == $past(wr_data) && cm_addr == $past(wr_addr));

  assert_timer_flush_R9: assert property (@(posedge clk) disable iff (rst)
    acc && regsp && wr_addr[ADDR_W-2:PAGE_BITS] == '0 && off == C_TMR |=> col_mask == 4'd0);

  assert_hold_payload_R11: assert property (@(posedge clk) disable iff (rst)
    cm_valid && !cm_ready |=> cm_valid && $stable(cm_data) && $stable(cm_addr) && $stable(cm_kind));

  assert_stall_input_R11: assert property (@(posedge clk) disable iff (rst)
    cm_valid && !cm_ready |-> !wr_ready);
endmodule

bind wide_write_collector wrc_checker #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .OFF_EVQ(OFF_EVQ),
  .OFF_TMR(OFF_TMR), .OFF_RXD(OFF_RXD), .OFF_TXD(OFF_TXD)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .cm_valid(cm_valid),
  .cm_ready(cm_ready), .cm_kind(cm_kind), .cm_addr(cm_addr),
  .cm_data(cm_data), .col_mask(col_mask)
);

// File: tb/wide_write_collector_tb.sv
`timescale 1ns/1ps
module wide_write_collector_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [19:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         cm_valid;
  logic         cm_ready = 1'b1;
  logic [1:0]   cm_kind;
  logic [19:0]  cm_addr;
  logic [127:0] cm_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  wide_write_collector u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .cm_valid(cm_valid),
    .cm_ready(cm_ready), .cm_kind(cm_kind), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic ev, input logic [1:0] k,
                            input logic [19:0] a, input logic [127:0] d);
    n_tests++;
    if (cm_valid !== ev || (ev && (cm_kind !== k || cm_addr !== a || cm_data !== d))) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b kind=%0d addr=%h data=%h, expected valid=%0b kind=%0d addr=%h data=%h",
               req, cm_valid, cm_kind, cm_addr, cm_data, ev, k, a, d);
    end
  endtask

  task automatic expect_none(input string req);
    expect_out(req, 1'b0, 2'd0, 20'd0, 128'd0);
  endtask

  task automatic t_reset();
    n_tests++;
    if (cm_valid !== 1'b0 || wr_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: got cm_valid=%0b wr_ready=%0b, expected 0 and 1", cm_valid, wr_ready);
    end
    wr(20'h0080C, 32'h1111_0003);
    expect_none("R1 lone dword after reset");
  endtask

  task automatic t_csr_order();
    wr(20'h00908, 32'hA2); expect_none("R2 partial");
    wr(20'h00900, 32'hA0); expect_none("R2 partial");
    wr(20'h0090C, 32'hA3); expect_none("R2 partial");
    wr(20'h00904, 32'hA1);
    expect_out("R2 full commit", 1'b1, 2'd2, 20'h00900, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
  endtask

  task automatic t_restart();
    wr(20'h00800, 32'hB0);
    wr(20'h00804, 32'hB1);
    wr(20'h00910, 32'hC0);
    wr(20'h00808, 32'hB2);
    wr(20'h0080C, 32'hB3);
    expect_none("R4 restart lost earlier dwords");
  endtask

  task automatic t_overwrite();
    wr(20'h00A00, 32'hDEAD);
    wr(20'h00A00, 32'hBEEF);
    wr(20'h00A04, 32'h1);
    wr(20'h00A08, 32'h2);
    wr(20'h00A0C, 32'h3);
    expect_out("R12 last write wins", 1'b1, 2'd2, 20'h00A00, {32'h3, 32'h2, 32'h1, 32'hBEEF});
  endtask

  task automatic t_sram();
    wr(20'h80010, 32'h5A5A_0000); expect_none("R3 half word");
    wr(20'h80014, 32'h5A5A_0001);
    expect_out("R3 sram commit", 1'b1, 2'd1, 20'h80010, {64'd0, 32'h5A5A_0001, 32'h5A5A_0000});
  endtask

  task automatic t_desc_full();
    wr(20'h00830, 32'hD0);
    wr(20'h00834, 32'hD1);
    wr(20'h00838, 32'hD2); expect_none("R7 low dwords held");
    wr(20'h0083C, 32'hD3);
    expect_out("R7 collected descriptor", 1'b1, 2'd3, 20'h00830, {32'hD3, 32'hD2, 32'hD1, 32'hD0});
  endtask

  task automatic t_desc_zero();
    wr(20'h06A14, 32'hE1);
    wr(20'h06A1C, 32'hE3);
    expect_out("R5 R10 zero fill page 3", 1'b1, 2'd3, 20'h06A10, {32'hE3, 32'd0, 32'hE1, 32'd0});
    wr(20'h02A1C, 32'hE7);
    expect_out("R5 top dword alone", 1'b1, 2'd3, 20'h02A10, {32'hE7, 96'd0});
  endtask

  task automatic t_desc_discard();
    wr(20'h00B00, 32'hF0);
    wr(20'h00B04, 32'hF1);
    wr(20'h00834, 32'h99); expect_none("R6 discarded low dword");
    wr(20'h00B08, 32'hF2);
    wr(20'h00B0C, 32'hF3);
    expect_out("R6 collector kept", 1'b1, 2'd2, 20'h00B00, {32'hF3, 32'hF2, 32'hF1, 32'hF0});
    wr(20'h00B00, 32'h70);
    wr(20'h0083C, 32'h77);
    expect_out("R5 foreign dwords not merged", 1'b1, 2'd3, 20'h00830, {32'h77, 96'd0});
    wr(20'h00B04, 32'h71);
    wr(20'h00B08, 32'h72);
    wr(20'h00B0C, 32'h73);
    expect_none("R5 collector cleared by commit");
  endtask

  task automatic t_direct();
    wr(20'h00C00, 32'h40);
    wr(20'h02400, 32'h1234);
    expect_out("R8 R10 direct page 1", 1'b1, 2'd0, 20'h02400, {96'd0, 32'h1234});
    wr(20'h02420, 32'h5678);
    expect_out("R9 timer page 1 direct", 1'b1, 2'd0, 20'h02420, {96'd0, 32'h5678});
    wr(20'h00C04, 32'h41);
    wr(20'h00C08, 32'h42);
    wr(20'h00C0C, 32'h43);
    expect_out("R8 R9 collector untouched", 1'b1, 2'd2, 20'h00C00, {32'h43, 32'h42, 32'h41, 32'h40});
  endtask

  task automatic t_timer();
    wr(20'h00D00, 32'h60);
    wr(20'h00D04, 32'h61);
    wr(20'h00D08, 32'h62);
    wr(20'h00420, 32'hCAFE);
    expect_out("R9 timer page 0 passes", 1'b1, 2'd0, 20'h00420, {96'd0, 32'hCAFE});
    wr(20'h00D0C, 32'h63);
    expect_none("R9 timer page 0 flushed");
  endtask

  task automatic t_backpressure();
    cm_ready = 1'b0;
    wr(20'h00400, 32'hAAAA);
    expect_out("R11 stalled commit", 1'b1, 2'd0, 20'h00400, {96'd0, 32'hAAAA});
    wr_valid = 1'b1;
    wr_addr  = 20'h02400;
    wr_data  = 32'hBBBB;
    repeat (3) @(negedge clk);
    n_tests++;
    if (wr_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: got wr_ready=%0b, expected 0", wr_ready);
    end
    expect_out("R11 payload held", 1'b1, 2'd0, 20'h00400, {96'd0, 32'hAAAA});
    cm_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    expect_out("R11 next after drain", 1'b1, 2'd0, 20'h02400, {96'd0, 32'hBBBB});
    @(negedge clk);
    expect_none("R11 drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_csr_order();
    t_restart();
    t_overwrite();
    t_sram();
    t_desc_full();
    t_desc_zero();
    t_desc_discard();
    t_direct();
    t_timer();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got no completion, expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule